// File: doc/BRIEF.md
# WFI clock-gating and power-down controller

This controller sits beside a processor core and its private L2 cache. It switches off their clock while the core idles in wait-for-interrupt (WFI). It switches the clock back on when there is a reason to run: a pending interrupt, a reset request, or traffic waiting on any receive channel of the interconnect. After such a wake-up it does not gate again straight away. The core must first leave WFI and then enter it again, so a core that is still working through the traffic that woke it keeps its clock.

The same controller also runs a power-down sequence when power-down is enabled. It asks the L2 to flush and waits for the flush to finish. It then waits for the core to reach WFI, raises a power-down request towards the SoC power controller, and holds that request until the power controller acknowledges it. If an interrupt or reset request arrives during the flush or the WFI wait, the sequence is abandoned and the controller returns to normal running.

Every pin is a plain level signal. No data flows through the block, so it has no valid/ready stream and no back-pressure rules. The request/acknowledge pair is a level handshake. All outputs are registered, so each input sampled at a rising edge shows its effect on the outputs just after that same edge. The registered enable drives a latch-based clock gate, and the gated clock for the core and L2 is brought out on a port.

Top module: `pmc_wfi_power_ctrl`

## Requirements
- R1: In normal running, if WFI is sampled high while the controller is armed, no wake source is present and power-down is disabled, `clk_en_o` goes low after that edge.
- R2: While gated, a sampled interrupt, reset request or flit-pending flag raises `clk_en_o` after that edge. While any of them is present in normal running, gating does not start.
- R3: Traffic wake-up is the OR of all `NUM_RX_CH` bits of `rx_flitpend_i`. Each bit on its own is enough to wake, and for every combination the wake result equals (irq OR reset request OR any flit bit).
- R4: After a wake-up from the gated state, and after reset, the controller is disarmed. It stays running, even with WFI held high, until WFI has been sampled low and then high again.
- R5: With power-down enabled and no interrupt or reset request, running moves to flush. `l2_flush_req_o` stays high until the flush-done flag is sampled. The controller then waits, clock on, for WFI, and then raises `pd_req_o` with the clock gated. Power-down enable takes priority over WFI gating, and `l2_flush_req_o` and `pd_req_o` are never high together.
- R6: `pd_req_o` stays high while the acknowledge is low and drops after the edge that samples the acknowledge. The controller then stays powered down, with the clock off and every request low, ignoring all wake sources until reset.
- R7: An interrupt or reset request sampled during the flush or the WFI wait aborts the sequence. After that edge both requests are low and the clock is enabled.
- R8: The synchronous reset gives `clk_en_o`=1, `l2_flush_req_o`=0 and `pd_req_o`=0 after the edge that samples it.
- R9: `gclk_o` gives one full pulse per clock cycle while the registered enable is high and none while it is low. The enable is captured only while the clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running controller clock |
| rst | input | 1 | Synchronous reset, active high |
| core_wfi_i | input | 1 | Core reports it is in WFI |
| irq_pend_i | input | 1 | Interrupt pending |
| rst_req_i | input | 1 | Reset requested for the core |
| rx_flitpend_i | input | NUM_RX_CH | Flit-pending flag per receive channel |
| pd_en_i | input | 1 | Power-down enabled |
| l2_flush_done_i | input | 1 | L2 flush complete |
| pd_ack_i | input | 1 | Power-down acknowledge from the SoC |
| clk_en_o | output | 1 | Registered clock enable for core plus L2 |
| gclk_o | output | 1 | Gated clock for core plus L2 |
| l2_flush_req_o | output | 1 | Request to flush the L2 |
| pd_req_o | output | 1 | Power-down request to the SoC |

## Verification
Two things can land on the same edge: a fresh WFI entry and a wake source, or a fresh WFI entry and power-down enable. The bench drives both at once in one cycle. When WFI rises together with each wake combination, the clock must stay on. When WFI rises together with power-down enable, the flush request must appear and the gate must not close. Every one of the 64 combinations of interrupt, reset request and the four flit flags is applied to the gated state. The expected enable is computed as the OR of the bits.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  typedef enum logic [2:0] {
    ST_RUN      = 3'd0,
    ST_GATED    = 3'd1,
    ST_FLUSH    = 3'd2,
    ST_WAIT_WFI = 3'd3,
    ST_PD_REQ   = 3'd4,
    ST_PD_DONE  = 3'd5
  } pmc_state_e;

  typedef struct packed {
    logic clk_en;
    logic flush_req;
    logic pd_req;
  } pmc_out_s;

  localparam pmc_out_s PMC_OUT_RESET = '{clk_en: 1'b1, flush_req: 1'b0, pd_req: 1'b0};

  // Output levels owned by each state
  function automatic pmc_out_s pmc_decode(pmc_state_e s);
    pmc_out_s o;
    o = PMC_OUT_RESET;
    case (s)
      ST_RUN:      o = PMC_OUT_RESET;
      ST_GATED:    o.clk_en = 1'b0;
      ST_FLUSH:    o.flush_req = 1'b1;
      ST_WAIT_WFI: o = PMC_OUT_RESET;
      ST_PD_REQ:   begin o.clk_en = 1'b0; o.pd_req = 1'b1; end
      ST_PD_DONE:  o.clk_en = 1'b0;
      default:     o = PMC_OUT_RESET;
    endcase
    return o;
  endfunction

endpackage

// File: rtl/pmc_wake_merge.sv
module pmc_wake_merge #(
  parameter int NUM_RX_CH = 4
) (
  input  logic                 irq_pend_i,
  input  logic                 rst_req_i,
  input  logic [NUM_RX_CH-1:0] rx_flitpend_i,
  output logic                 urgent_o,
  output logic                 traffic_o,
  output logic                 wake_any_o
);

  // OR chain over every receive channel
  logic [NUM_RX_CH:0] chain;
  assign chain[0] = 1'b0;

  for (genvar g = 0; g < NUM_RX_CH; g++) begin : g_chan
    assign chain[g+1] = chain[g] | rx_flitpend_i[g];
  end

  assign traffic_o  = chain[NUM_RX_CH];
  assign urgent_o   = irq_pend_i | rst_req_i;
  assign wake_any_o = urgent_o | traffic_o;

endmodule

// File: rtl/pmc_entry_detect.sv
module pmc_entry_detect (
  input  logic clk,
  input  logic rst,
  input  logic core_wfi_i,
  input  logic disarm_i,
  output logic armed_o,
  output logic fresh_o
);

  logic armed_q;

  // Armed once WFI is seen low; cleared by reset and by each wake-up
  always_ff @(posedge clk) begin
    if (rst)              armed_q <= 1'b0;
    else if (disarm_i)    armed_q <= 1'b0;
    else if (!core_wfi_i) armed_q <= 1'b1;
  end

  assign armed_o = armed_q;
  assign fresh_o = armed_q & core_wfi_i;

endmodule

// File: rtl/pmc_seq_fsm.sv
module pmc_seq_fsm
  import pmc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       fresh_i,
  input  logic       wake_any_i,
  input  logic       urgent_i,
  input  logic       core_wfi_i,
  input  logic       pd_en_i,
  input  logic       flush_done_i,
  input  logic       pd_ack_i,
  output pmc_state_e state_o,
  output logic       wake_exit_o,
  output pmc_out_s   out_o
);

  pmc_state_e state_q, state_d;
  pmc_out_s   out_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_RUN: begin
        if (pd_en_i && !urgent_i)        state_d = ST_FLUSH;
        else if (fresh_i && !wake_any_i) state_d = ST_GATED;
      end
      ST_GATED: begin
        if (wake_any_i) state_d = ST_RUN;
      end
      ST_FLUSH: begin
        if (urgent_i)          state_d = ST_RUN;
        else if (flush_done_i) state_d = ST_WAIT_WFI;
      end
      ST_WAIT_WFI: begin
        if (urgent_i)        state_d = ST_RUN;
        else if (core_wfi_i) state_d = ST_PD_REQ;
      end
      ST_PD_REQ: begin
        if (pd_ack_i) state_d = ST_PD_DONE;
      end
      ST_PD_DONE: state_d = ST_PD_DONE;
      default:    state_d = ST_RUN;
    endcase
  end

  // Outputs registered from the next state: glitch-free, same edge as state
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_RUN;
      out_q   <= PMC_OUT_RESET;
    end else begin
      state_q <= state_d;
      out_q   <= pmc_decode(state_d);
    end
  end

  assign state_o     = state_q;
  assign wake_exit_o = (state_q == ST_GATED) && wake_any_i;
  assign out_o       = out_q;

endmodule

// File: rtl/pmc_clk_gate.sv
module pmc_clk_gate (
  input  logic clk,
  input  logic en_i,
  output logic gclk_o
);

  logic en_lat;

  // Transparent while clk is low, so the enable settles before the rising edge
  always_latch begin
    if (!clk) en_lat = en_i;
  end

  assign gclk_o = clk & en_lat;

endmodule

// File: rtl/pmc_wfi_power_ctrl.sv
module pmc_wfi_power_ctrl
  import pmc_pkg::*;
#(
  parameter int NUM_RX_CH = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 core_wfi_i,
  input  logic                 irq_pend_i,
  input  logic                 rst_req_i,
  input  logic [NUM_RX_CH-1:0] rx_flitpend_i,
  input  logic                 pd_en_i,
  input  logic                 l2_flush_done_i,
  input  logic                 pd_ack_i,
  output logic                 clk_en_o,
  output logic                 gclk_o,
  output logic                 l2_flush_req_o,
  output logic                 pd_req_o
);

  logic       urgent, traffic, wake_any;
  logic       armed, fresh, wake_exit;
  pmc_state_e state_q;
  pmc_out_s   outs;

  pmc_wake_merge #(.NUM_RX_CH(NUM_RX_CH)) u_wake (
    .irq_pend_i   (irq_pend_i),
    .rst_req_i    (rst_req_i),
    .rx_flitpend_i(rx_flitpend_i),
    .urgent_o     (urgent),
    .traffic_o    (traffic),
    .wake_any_o   (wake_any)
  );

  pmc_entry_detect u_entry (
    .clk       (clk),
    .rst       (rst),
    .core_wfi_i(core_wfi_i),
    .disarm_i  (wake_exit),
    .armed_o   (armed),
    .fresh_o   (fresh)
  );

  pmc_seq_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .fresh_i     (fresh),
    .wake_any_i  (wake_any),
    .urgent_i    (urgent),
    .core_wfi_i  (core_wfi_i),
    .pd_en_i     (pd_en_i),
    .flush_done_i(l2_flush_done_i),
    .pd_ack_i    (pd_ack_i),
    .state_o     (state_q),
    .wake_exit_o (wake_exit),
    .out_o       (outs)
  );

  pmc_clk_gate u_cg (
    .clk   (clk),
    .en_i  (outs.clk_en),
    .gclk_o(gclk_o)
  );

  assign clk_en_o       = outs.clk_en;
  assign l2_flush_req_o = outs.flush_req;
  assign pd_req_o       = outs.pd_req;

endmodule

// File: rtl/pmc_wfi_power_ctrl_chk.sv
module pmc_wfi_power_ctrl_chk
  import pmc_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       core_wfi_i,
  input logic       pd_en_i,
  input logic       pd_ack_i,
  input logic       wake_any,
  input logic       urgent,
  input logic       armed,
  input pmc_state_e state_q,
  input logic       clk_en_o,
  input logic       l2_flush_req_o,
  input logic       pd_req_o
);

  a_r1_gate_on_entry: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && core_wfi_i && armed && !wake_any && !pd_en_i) |=> !clk_en_o);

  a_r2_wake_restores: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_GATED && wake_any) |=> (clk_en_o && state_q == ST_RUN));

  a_r4_disarmed_runs: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && !armed) |=> clk_en_o);

  a_r5_flush_from_run: assert property (@(posedge clk) disable iff (rst)
    $rose(l2_flush_req_o) |-> $past(state_q) == ST_RUN);

  a_r5_pd_after_wait: assert property (@(posedge clk) disable iff (rst)
    $rose(pd_req_o) |-> $past(state_q) == ST_WAIT_WFI);

  a_r5_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(l2_flush_req_o && pd_req_o));

  a_r6_hold_req: assert property (@(posedge clk) disable iff (rst)
    (pd_req_o && !pd_ack_i) |=> pd_req_o);

  a_r6_terminal: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_PD_DONE) |=> (state_q == ST_PD_DONE && !clk_en_o && !pd_req_o));

  a_r7_abort: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_FLUSH || state_q == ST_WAIT_WFI) && urgent) |=>
      (state_q == ST_RUN && !l2_flush_req_o && !pd_req_o && clk_en_o));

  // R8: outputs after a sampled reset
  logic rst_seen;
  always_ff @(posedge clk) rst_seen <= rst;
  always @(negedge clk) begin
    if (rst_seen === 1'b1)
      a_r8_reset_state: assert (clk_en_o && !l2_flush_req_o && !pd_req_o);
  end

endmodule

bind pmc_wfi_power_ctrl pmc_wfi_power_ctrl_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .core_wfi_i    (core_wfi_i),
  .pd_en_i       (pd_en_i),
  .pd_ack_i      (pd_ack_i),
  .wake_any      (wake_any),
  .urgent        (urgent),
  .armed         (armed),
  .state_q       (state_q),
  .clk_en_o      (clk_en_o),
  .l2_flush_req_o(l2_flush_req_o),
  .pd_req_o      (pd_req_o)
);

// File: tb/sim_pmc_wfi_power_ctrl.sv
`timescale 1ns/1ps
module sim_pmc_wfi_power_ctrl;

  localparam int NCH = 4;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           core_wfi = 1'b0, irq = 1'b0, rreq = 1'b0;
  logic [NCH-1:0] flit = '0;
  logic           pd_en = 1'b0, fdone = 1'b0, ack = 1'b0;
  logic           clk_en, gclk, freq, preq;

  int n_chk = 0;
  int n_bad = 0;
  int gcnt  = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  pmc_wfi_power_ctrl #(.NUM_RX_CH(NCH)) u0 (
    .clk(clk), .rst(rst), .core_wfi_i(core_wfi), .irq_pend_i(irq),
    .rst_req_i(rreq), .rx_flitpend_i(flit), .pd_en_i(pd_en),
    .l2_flush_done_i(fdone), .pd_ack_i(ack), .clk_en_o(clk_en),
    .gclk_o(gclk), .l2_flush_req_o(freq), .pd_req_o(preq)
  );

  always @(posedge gclk) gcnt++;

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  // WFI low for one edge (arms), then high (fresh entry)
  task automatic enter_gate();
    core_wfi = 1'b0; step();
    core_wfi = 1'b1; step();
  endtask

  task automatic do_reset();
    rst = 1'b1; step(2);
    chk("R8 clk_en", clk_en, 1'b1);
    chk("R8 flush_req", freq, 1'b0);
    chk("R8 pd_req", preq, 1'b0);
    rst = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    do_reset();

    // R9: clock pulses while running
    gcnt = 0; step(3);
    chk("R9 running pulses", gcnt == 3, 1'b1);

    // R4: reset with WFI high does not gate until re-entry
    core_wfi = 1'b1;
    do_reset();
    step(3);
    chk("R4 disarmed after reset", clk_en, 1'b1);
    enter_gate();
    chk("R1 gated on fresh entry", clk_en, 1'b0);
    gcnt = 0; step(3);
    chk("R9 gated no pulses", gcnt == 0, 1'b1);
    irq = 1'b1; step(); irq = 1'b0;

    // R2/R3: sweep every wake combination against the gated state
    for (int code = 0; code < 64; code++) begin
      logic exp_wake;
      enter_gate();
      chk("R1 gate before sweep", clk_en, 1'b0);
      irq  = code[5];
      rreq = code[4];
      flit = code[3:0];
      exp_wake = (code[5] | code[4] | (|code[3:0]));
      step();
      chk($sformatf("R3 wake code=%0d", code), clk_en, exp_wake);
      if (!exp_wake) begin
        irq = 1'b1; step();
        chk("R2 irq wake", clk_en, 1'b1);
      end
      irq = 1'b0; rreq = 1'b0; flit = '0;
      step(3);
      chk("R4 no regate with WFI held", clk_en, 1'b1);
    end

    // R2: WFI entry coinciding with traffic does not gate
    core_wfi = 1'b0; step();
    core_wfi = 1'b1; flit = 4'b0100; step();
    chk("R2 no gate while traffic", clk_en, 1'b1);
    flit = '0; step();
    chk("R2 gate after traffic gone", clk_en, 1'b0);
    rreq = 1'b1; step(); rreq = 1'b0;
    chk("R2 reset request wakes", clk_en, 1'b1);

    // R5: power-down order, with pd enable colliding with WFI entry
    core_wfi = 1'b0; step();
    core_wfi = 1'b1; pd_en = 1'b1; step();
    chk("R5 flush priority", freq, 1'b1);
    chk("R5 clock on in flush", clk_en, 1'b1);
    step(3);
    chk("R5 flush held", freq, 1'b1);
    chk("R5 no pd in flush", preq, 1'b0);
    fdone = 1'b1; core_wfi = 1'b0; step(); fdone = 1'b0;
    chk("R5 flush dropped", freq, 1'b0);
    step(2);
    chk("R5 waiting for WFI", preq, 1'b0);
    chk("R5 clock on while waiting", clk_en, 1'b1);
    core_wfi = 1'b1; step();
    chk("R5 pd request", preq, 1'b1);
    chk("R5 clock gated in pd", clk_en, 1'b0);
    gcnt = 0; step(4);
    chk("R6 request held", preq, 1'b1);
    chk("R9 no pulses in pd", gcnt == 0, 1'b1);
    ack = 1'b1; step(); ack = 1'b0;
    chk("R6 request dropped", preq, 1'b0);
    irq = 1'b1; rreq = 1'b1; flit = '1; step(3);
    chk("R6 terminal clock off", clk_en, 1'b0);
    chk("R6 terminal no flush", freq, 1'b0);
    chk("R6 terminal no pd", preq, 1'b0);
    irq = 1'b0; rreq = 1'b0; flit = '0; pd_en = 1'b0; core_wfi = 1'b0;
    do_reset();

    // R7: abort during flush
    pd_en = 1'b1; step();
    chk("R7 in flush", freq, 1'b1);
    irq = 1'b1; pd_en = 1'b0; step(); irq = 1'b0;
    chk("R7 flush aborted", freq, 1'b0);
    chk("R7 clock on", clk_en, 1'b1);
    step();
    chk("R7 stays running", freq, 1'b0);

    // R7: abort during WFI wait, colliding with WFI rise
    pd_en = 1'b1; step();
    fdone = 1'b1; step(); fdone = 1'b0; pd_en = 1'b0;
    rreq = 1'b1; core_wfi = 1'b1; step(); rreq = 1'b0;
    chk("R7 wait aborted no pd", preq, 1'b0);
    chk("R7 wait aborted clock on", clk_en, 1'b1);
    step();
    chk("R1 gates after abort", clk_en, 1'b0);
    chk("R7 still no pd", preq, 1'b0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule